// File: doc/BRIEF.md
# Single-Level Interrupt Cycle Sequencer

This block decides, at the start of every machine cycle of a small accumulator computer, whether the next cycle is an ordinary instruction fetch or a hardware interrupt cycle, and it runs that interrupt cycle itself. It watches the interrupt-enable flip-flop, the keyboard-ready and printer-ready flags, and the step value of the external sequence counter. Outside the fetch and decode steps it arms a pending flip-flop. When the sequence counter wraps back to step 0 with that flip-flop armed, it issues a three-step sequence. The sequence stores the interrupted program counter in memory word 0, forces the program counter to 1, and turns further interrupts off.

The surrounding control unit keeps ownership of the program counter, the address register, memory and the sequence counter. This block only raises strobes toward them for one cycle each. It also holds the temporary register that carries the return address into memory. The instruction decoder feeds the enable/disable instructions in as one-cycle strobes, and the block owns the enable flip-flop.

Top module: `irqseq_top`

## Requirements
- R1: While `rstN` is low, `intPending`, `ienOut` and every strobe output (`arClr`, `memWe`, `pcClr`, `pcInc`, `scClr`) are 0.
- R2: A cycle with `ionStrobe`=1 sets `ienOut` to 1 at the next edge. A cycle with `iofStrobe`=1 clears it. When both strobes are 1 in the same cycle, `ienOut` becomes 0.
- R3: When `ienOut`=1, `fgi` or `fgo` is 1, and `tStep` is 3 or higher, `intPending` is 1 after the next edge.
- R4: While `tStep` is 0, 1 or 2, an idle `intPending` stays 0 whatever the flags and enable are.
- R5: With `ienOut`=0, or with both `fgi` and `fgo` at 0, an idle `intPending` stays 0.
- R6: When `intPending`=1 and `tStep`=0, `arClr` is 1 and `pcIn` is captured. From the next cycle, `memWdata` shows that value zero-extended.
- R7: When `intPending`=1 and `tStep`=1, `memWe` and `pcClr` are 1, and `memWdata` holds the program counter captured in step 0 (the write goes to word 0, the address register having been cleared).
- R8: When `intPending`=1 and `tStep`=2, `pcInc` and `scClr` are 1. After the edge, `intPending` and `ienOut` are both 0.
- R9: While `intPending`=0, all strobe outputs stay 0 at every value of `tStep`.
- R10: Flag activity during the interrupt cycle does not keep `intPending` armed. After step 2, `intPending` is 0 and stays 0 until the enable is set again.
- R11: An `ionStrobe` in the same cycle as interrupt step 2 leaves `ienOut` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tStep | input | SC_W | Current sequence-counter step (0 = T0) |
| ionStrobe | input | 1 | Enable-interrupts instruction executing |
| iofStrobe | input | 1 | Disable-interrupts instruction executing |
| fgi | input | 1 | Input-ready flag |
| fgo | input | 1 | Output-ready flag |
| pcIn | input | AW | Current program counter |
| intPending | output | 1 | Pending interrupt flip-flop |
| ienOut | output | 1 | Interrupt enable flip-flop |
| arClr | output | 1 | Clear address register |
| memWe | output | 1 | Write `memWdata` to memory word 0 |
| memWdata | output | DW | Saved return address, zero-extended |
| pcClr | output | 1 | Clear program counter |
| pcInc | output | 1 | Increment program counter |
| scClr | output | 1 | Clear sequence counter |

## Verification
The bench builds the block with its defaults: a 4-bit step input, a 12-bit program counter and 16-bit memory words. The 4-bit step lets random stimulus visit every step from 0 to 15. This covers both sides of the step-2 boundary that gates arming, and out-of-order steps while an interrupt is pending. The 12-bit counter puts the all-ones return address and the zero-extension into the upper four data bits within reach. Directed runs cover the clean T3→T0→T1→T2 path, flags that toggle mid-sequence, and the collisions between the two enable strobes and step 2.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  // One-cycle control strobes from the sequencer control to the datapath and the chip
  typedef struct packed {
    logic arClr;
    logic trLoad;
    logic memWe;
    logic pcClr;
    logic pcInc;
    logic scClr;
  } strobe_t;

endpackage

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
#(
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SC_W-1:0] tStep,
  input  logic            ionStrobe,
  input  logic            iofStrobe,
  input  logic            fgi,
  input  logic            fgo,
  output strobe_t         strb,
  output logic            rPend,
  output logic            ienQ
);

  localparam logic [SC_W-1:0] STEP0 = SC_W'(0);
  localparam logic [SC_W-1:0] STEP1 = SC_W'(1);
  localparam logic [SC_W-1:0] STEP2 = SC_W'(2);

  logic inSeq0, inSeq1, inSeq2, armOk;

  assign inSeq0 = rPend && (tStep == STEP0);
  assign inSeq1 = rPend && (tStep == STEP1);
  assign inSeq2 = rPend && (tStep == STEP2);
  // arming is only allowed past the fetch/decode steps
  assign armOk  = ienQ && (fgi || fgo) && (tStep > STEP2);

  always_ff @(posedge clk) begin
    if (!rstN)       rPend <= 1'b0;
    else if (inSeq2) rPend <= 1'b0;
    else if (armOk)  rPend <= 1'b1;
  end

  // sequence completion has priority over both instruction strobes
  always_ff @(posedge clk) begin
    if (!rstN)          ienQ <= 1'b0;
    else if (inSeq2)    ienQ <= 1'b0;
    else if (iofStrobe) ienQ <= 1'b0;
    else if (ionStrobe) ienQ <= 1'b1;
  end

  always_comb begin
    strb        = '0;
    strb.arClr  = inSeq0;
    strb.trLoad = inSeq0;
    strb.memWe  = inSeq1;
    strb.pcClr  = inSeq1;
    strb.pcInc  = inSeq2;
    strb.scClr  = inSeq2;
  end

  a_r3_arm: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ && (fgi || fgo) && (tStep > STEP2) && !rPend) |=> rPend);

  a_r4_no_early_arm: assert property (@(posedge clk) disable iff (!rstN)
    (!rPend && (tStep <= STEP2)) |=> !rPend);

  a_r5_no_arm_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!rPend && (!ienQ || !(fgi || fgo))) |=> !rPend);

  a_r8_done: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scClr) |=> (!rPend && !ienQ));

  a_r2_ion: assert property (@(posedge clk) disable iff (!rstN)
    (ionStrobe && !iofStrobe && !strb.pcInc) |=> ienQ);

  a_r2_iof: assert property (@(posedge clk) disable iff (!rstN)
    iofStrobe |=> !ienQ);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rPend |-> !(strb.arClr || strb.memWe || strb.pcClr || strb.pcInc || strb.scClr));

  a_r7_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.arClr, strb.memWe, strb.pcInc}));

endmodule

// File: rtl/irqseq_dp.sv
module irqseq_dp
  import irqseq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] pcIn,
  output logic [DW-1:0] memWdata
);

  logic [AW-1:0] trReg;

  always_ff @(posedge clk) begin
    if (!rstN)            trReg <= '0;
    else if (strb.trLoad) trReg <= pcIn;
  end

  generate
    if (DW > AW) begin : g_ext
      assign memWdata = {{(DW-AW){1'b0}}, trReg};
    end else begin : g_trunc
      assign memWdata = trReg[DW-1:0];
    end
  endgenerate

  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.trLoad |=> (memWdata == DW'($past(pcIn))));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.trLoad |=> $stable(memWdata));

endmodule

// File: rtl/irqseq_top.sv
module irqseq_top
  import irqseq_pkg::*;
#(
  parameter int SC_W = 4,
  parameter int AW   = 12,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SC_W-1:0] tStep,
  input  logic            ionStrobe,
  input  logic            iofStrobe,
  input  logic            fgi,
  input  logic            fgo,
  input  logic [AW-1:0]   pcIn,
  output logic            intPending,
  output logic            ienOut,
  output logic            arClr,
  output logic            memWe,
  output logic [DW-1:0]   memWdata,
  output logic            pcClr,
  output logic            pcInc,
  output logic            scClr
);

  strobe_t strb;

  irqseq_ctrl #(.SC_W(SC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tStep(tStep),
    .ionStrobe(ionStrobe), .iofStrobe(iofStrobe),
    .fgi(fgi), .fgo(fgo),
    .strb(strb), .rPend(intPending), .ienQ(ienOut)
  );

  irqseq_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .memWdata(memWdata)
  );

  assign arClr = strb.arClr;
  assign memWe = strb.memWe;
  assign pcClr = strb.pcClr;
  assign pcInc = strb.pcInc;
  assign scClr = strb.scClr;

endmodule

// File: tb/irqseq_top_test.sv
`timescale 1ns/1ps
module irqseq_top_test;

  localparam int SC_W = 4;
  localparam int AW   = 12;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SC_W-1:0] tStep = '0;
  logic ionStrobe = 1'b0, iofStrobe = 1'b0, fgi = 1'b0, fgo = 1'b0;
  logic [AW-1:0] pcIn = '0;
  logic intPending, ienOut, arClr, memWe, pcClr, pcInc, scClr;
  logic [DW-1:0] memWdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  bit mR = 0, mIen = 0;
  logic [AW-1:0] mTr = '0;

  always #4 clk = ~clk;

  irqseq_top #(.SC_W(SC_W), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .tStep(tStep), .ionStrobe(ionStrobe),
    .iofStrobe(iofStrobe), .fgi(fgi), .fgo(fgo), .pcIn(pcIn),
    .intPending(intPending), .ienOut(ienOut), .arClr(arClr), .memWe(memWe),
    .memWdata(memWdata), .pcClr(pcClr), .pcInc(pcInc), .scClr(scClr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expStrobe(input bit r, input logic [SC_W-1:0] t, input int k);
    return r && (t == SC_W'(k));
  endfunction

  // drive one cycle, check outputs against the model, then advance the model
  task automatic step(input logic [SC_W-1:0] t, input bit ion, input bit iof,
                      input bit fi, input bit fo, input logic [AW-1:0] pc);
    bit nR, nIen;
    logic [AW-1:0] nTr;
    @(negedge clk);
    tStep = t; ionStrobe = ion; iofStrobe = iof; fgi = fi; fgo = fo; pcIn = pc;
    #1;
    check("R3/R4/R5/R10 pending", intPending, mR);
    check("R2/R8/R11 enable", ienOut, mIen);
    check("R6/R9 arClr", arClr, expStrobe(mR, t, 0));
    check("R7/R9 memWe", memWe, expStrobe(mR, t, 1));
    check("R7/R9 pcClr", pcClr, expStrobe(mR, t, 1));
    check("R8/R9 pcInc", pcInc, expStrobe(mR, t, 2));
    check("R8/R9 scClr", scClr, expStrobe(mR, t, 2));
    check("R6/R7 memWdata", memWdata, DW'(mTr));
    nR = mR; nIen = mIen; nTr = mTr;
    if (expStrobe(mR, t, 2)) begin nR = 0; nIen = 0; end
    else begin
      if (mIen && (fi || fo) && (t > SC_W'(2))) nR = 1;
      if (iof) nIen = 0; else if (ion) nIen = 1;
    end
    if (expStrobe(mR, t, 0)) nTr = pc;
    @(posedge clk);
    mR = nR; mIen = nIen; mTr = nTr;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1234);
    // R1: reset state
    rstN = 1'b0; tStep = 4'd5; fgi = 1; fgo = 1; ionStrobe = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pending", intPending, 0);
    check("R1 enable", ienOut, 0);
    check("R1 strobes", {arClr, memWe, pcClr, pcInc, scClr}, 0);
    rstN = 1'b1; ionStrobe = 0;

    // R5: flags high but interrupts disabled
    step(4'd4, 0, 0, 1, 1, 12'h100);
    step(4'd5, 0, 0, 1, 0, 12'h100);
    // R2: enable, then both strobes together clear
    step(4'd3, 1, 0, 0, 0, 12'h100);
    step(4'd4, 1, 1, 0, 0, 12'h100);
    step(4'd5, 1, 0, 0, 0, 12'h100);
    // R4: conditions met during steps 0..2 do not arm
    step(4'd0, 0, 0, 1, 0, 12'h101);
    step(4'd1, 0, 0, 0, 1, 12'h101);
    step(4'd2, 0, 0, 1, 1, 12'h101);
    // R3: arm at step 3
    step(4'd3, 0, 0, 1, 0, 12'hFFF);
    // R6/R7/R8/R10: full interrupt cycle with all-ones PC, flags toggling, ION at step 2 (R11)
    step(4'd4, 0, 0, 0, 1, 12'hFFF);
    step(4'd0, 0, 0, 1, 1, 12'hFFF);
    step(4'd1, 0, 0, 0, 0, 12'h000);
    step(4'd2, 1, 0, 1, 1, 12'h000);
    // R10: afterwards R stays clear while flags stay high
    step(4'd3, 0, 0, 1, 1, 12'h001);
    step(4'd7, 0, 0, 1, 1, 12'h001);
    check("R10 pending stays clear", intPending, 0);

    // random stimulus
    for (int i = 0; i < 4000; i++) begin
      logic [SC_W-1:0] t;
      t = SC_W'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) t = SC_W'($urandom_range(0, 3));
      step(t, $urandom_range(0, 5) == 0, $urandom_range(0, 11) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, AW'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule